// File: doc/BRIEF.md
# Power-Mode Supervisor State Machine

This block chooses the operating mode of a power and bus-interface chip. It has five modes: Off, Reset, Standby, Normal and Overtemp. Its inputs are synchronous flags from analog comparators and pins. Its outputs enable the supply regulator and the bus transceiver, drive the active-low reset line toward the host, and force the receive line low when a bus wake-up arrives in Standby. Every input is sampled on the rising clock edge, and the mode changes at that same edge.

Faults are ranked. A battery undervoltage wins over everything else. An overtemperature event comes next, then a reset event, then the standby request. Leaving Off or Overtemp always passes through Reset. While in Reset, the block holds the reset output low for a programmable number of cycles. It moves on to Standby only after the reset line is seen high.

Top module: `pwr_mode_sup`

## Requirements
- R1: `mode_oh` is always one-hot, with bit 0 = Off, bit 1 = Reset, bit 2 = Standby, bit 3 = Normal and bit 4 = Overtemp. After `rst_n` low the mode is Off, and `reg_en`, `xcvr_en`, `rstn_out` and `rxd_low` are all 0.
- R2: When `bat_uv` is high, the mode becomes Off at the next edge from any mode, whatever the other inputs are.
- R3: When `ot_event` is high and `bat_uv` is low, the mode becomes Overtemp at the next edge from any mode except Off. This wins over reset events and over `stby_n`.
- R4: In Off with `bat_uv` low, `bat_pon` high moves the block to Reset at the next edge. Otherwise it stays in Off. `reg_uv` and `ot_event` have no effect in Off.
- R5: In Overtemp with `bat_uv` low and `ot_event` low, `ot_release` high moves the block to Reset. Otherwise it stays in Overtemp.
- R6: `rstn_out` is 0 for the first RST_CYC cycles spent in Reset. It is 1 from the next cycle on while `reg_uv` is low. `reg_uv` high in Reset restarts this count. Reset moves to Standby at the first edge where `rstn_out` is 1 and `rst_pin` is 1.
- R7: In Standby or Normal, `reg_uv` high or `rst_pin` low is a reset event and moves the block to Reset at the next edge. In Reset, `reg_uv` keeps the block in Reset. `rstn_out` is 0 in Off and Overtemp and 1 in Standby and Normal.
- R8: In Standby, `stby_n` = 1 selects Normal. In Normal, `stby_n` = 0 selects Standby. `reg_en` is 1 exactly in Reset, Standby and Normal. `xcvr_en` is 1 only in Normal.
- R9: `bus_wake` high at an edge where the block is in Standby and stays in Standby sets `rxd_low` to 1 from the next cycle. `rxd_low` stays 1 until the edge that leaves Standby clears it. `bus_wake` in any other mode is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| bat_pon | input | 1 | Battery above power-on threshold |
| bat_uv | input | 1 | Battery undervoltage |
| reg_uv | input | 1 | Regulator output undervoltage |
| ot_event | input | 1 | Overtemperature detected |
| ot_release | input | 1 | Temperature below release threshold |
| stby_n | input | 1 | Standby request pin, low selects Standby |
| rst_pin | input | 1 | Sensed level of the reset line |
| bus_wake | input | 1 | Bus wake-up detected |
| mode_oh | output | 5 | One-hot current mode |
| reg_en | output | 1 | Regulator enable |
| xcvr_en | output | 1 | Transceiver enable |
| rstn_out | output | 1 | Reset line drive, 0 pulls low |
| rxd_low | output | 1 | Receive line forced low on wake-up |

## Verification
The bench builds the block with RST_CYC = 3, so a full pass through Reset takes only four cycles. This makes it cheap to reach every mode again and again. The bench then sweeps all 32 combinations of battery undervoltage, overtemperature, regulator undervoltage, the exit condition and the standby pin from each of the five modes. Every priority conflict is covered this way. Directed runs cover the exact release cycle of the reset output, a restart of the count by `reg_uv`, an externally held reset line, and the set, hold and clear of the wake-up flag.

// File: rtl/pms_pkg.sv
package pms_pkg;
  localparam int NMODE = 5;

  typedef enum logic [2:0] {
    M_OFF   = 3'd0,
    M_RESET = 3'd1,
    M_STBY  = 3'd2,
    M_NORM  = 3'd3,
    M_OT    = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    C_NONE  = 2'd0,
    C_BATUV = 2'd1,
    C_OT    = 2'd2,
    C_RSTEV = 2'd3
  } cause_e;

  function automatic logic [NMODE-1:0] mode_onehot(mode_e m);
    logic [NMODE-1:0] v;
    v = '0;
    v[m] = 1'b1;
    return v;
  endfunction

  function automatic logic supply_on(mode_e m);
    return (m == M_RESET) || (m == M_STBY) || (m == M_NORM);
  endfunction

  function automatic logic host_running(mode_e m);
    return (m == M_STBY) || (m == M_NORM);
  endfunction
endpackage

// File: rtl/pms_fault_arb.sv
module pms_fault_arb
  import pms_pkg::*;
(
  input  mode_e  mode_q,
  input  logic   bat_uv,
  input  logic   ot_event,
  input  logic   reg_uv,
  input  logic   rst_pin,
  output logic   rst_ev,
  output cause_e cause
);
  logic pin_pulled;

  assign pin_pulled = !rst_pin && host_running(mode_q);
  assign rst_ev     = reg_uv || pin_pulled;

  always_comb begin
    if (bat_uv)
      cause = C_BATUV;
    else if (ot_event && (mode_q != M_OFF))
      cause = C_OT;
    else if (rst_ev && supply_on(mode_q))
      cause = C_RSTEV;
    else
      cause = C_NONE;
  end
endmodule

// File: rtl/pms_mode_fsm.sv
module pms_mode_fsm
  import pms_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  cause_e cause,
  input  logic   bat_pon,
  input  logic   ot_release,
  input  logic   stby_n,
  input  logic   rst_release,
  input  logic   rst_pin,
  output mode_e  mode_q,
  output mode_e  mode_d
);
  always_comb begin
    unique case (cause)
      C_BATUV: mode_d = M_OFF;
      C_OT:    mode_d = M_OT;
      C_RSTEV: mode_d = M_RESET;
      default: begin
        unique case (mode_q)
          M_OFF:   mode_d = bat_pon ? M_RESET : M_OFF;
          M_OT:    mode_d = ot_release ? M_RESET : M_OT;
          M_RESET: mode_d = (rst_release && rst_pin) ? M_STBY : M_RESET;
          M_STBY:  mode_d = stby_n ? M_NORM : M_STBY;
          M_NORM:  mode_d = stby_n ? M_NORM : M_STBY;
          default: mode_d = M_OFF;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mode_q <= M_OFF;
    else
      mode_q <= mode_d;
  end
endmodule

// File: rtl/pms_rst_timer.sv
module pms_rst_timer
  import pms_pkg::*;
#(
  parameter int RST_CYC = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  mode_e mode_q,
  input  mode_e mode_d,
  input  logic  reg_uv,
  output logic  rst_release
);
  localparam int CW = (RST_CYC < 1) ? 1 : $clog2(RST_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(RST_CYC);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          staying;

  assign staying     = (mode_q == M_RESET) && (mode_d == M_RESET) && !reg_uv;
  assign rst_release = (mode_q == M_RESET) && (cnt_q == LIM) && !reg_uv;

  always_comb begin
    if (!staying)
      cnt_d = '0;
    else if (cnt_q == LIM)
      cnt_d = cnt_q;
    else
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pms_wake_latch.sv
module pms_wake_latch
  import pms_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_e mode_q,
  input  mode_e mode_d,
  input  logic  bus_wake,
  output logic  wake_set,
  output logic  wake_q
);
  logic keep;

  assign keep     = (mode_q == M_STBY) && (mode_d == M_STBY);
  assign wake_set = keep && bus_wake;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wake_q <= 1'b0;
    else
      wake_q <= keep && (wake_q || bus_wake);
  end
endmodule

// File: rtl/pwr_mode_sup.sv
module pwr_mode_sup
  import pms_pkg::*;
#(
  parameter int RST_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bat_pon,
  input  logic             bat_uv,
  input  logic             reg_uv,
  input  logic             ot_event,
  input  logic             ot_release,
  input  logic             stby_n,
  input  logic             rst_pin,
  input  logic             bus_wake,
  output logic [NMODE-1:0] mode_oh,
  output logic             reg_en,
  output logic             xcvr_en,
  output logic             rstn_out,
  output logic             rxd_low
);
  mode_e  mode_q;
  mode_e  mode_d;
  cause_e cause;
  logic   rst_ev;
  logic   rst_release;
  logic   wake_set;
  logic   wake_q;

  pms_fault_arb u_arb (
    .mode_q   (mode_q),
    .bat_uv   (bat_uv),
    .ot_event (ot_event),
    .reg_uv   (reg_uv),
    .rst_pin  (rst_pin),
    .rst_ev   (rst_ev),
    .cause    (cause)
  );

  pms_mode_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .cause       (cause),
    .bat_pon     (bat_pon),
    .ot_release  (ot_release),
    .stby_n      (stby_n),
    .rst_release (rst_release),
    .rst_pin     (rst_pin),
    .mode_q      (mode_q),
    .mode_d      (mode_d)
  );

  pms_rst_timer #(.RST_CYC(RST_CYC)) u_tmr (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_q      (mode_q),
    .mode_d      (mode_d),
    .reg_uv      (reg_uv),
    .rst_release (rst_release)
  );

  pms_wake_latch u_wake (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_q   (mode_q),
    .mode_d   (mode_d),
    .bus_wake (bus_wake),
    .wake_set (wake_set),
    .wake_q   (wake_q)
  );

  assign mode_oh  = mode_onehot(mode_q);
  assign reg_en   = supply_on(mode_q);
  assign xcvr_en  = (mode_q == M_NORM);
  assign rstn_out = host_running(mode_q) || rst_release;
  assign rxd_low  = wake_q;
endmodule

// File: rtl/pms_checker.sv
module pms_checker #(
  parameter int RST_CYC = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bat_pon,
  input logic       bat_uv,
  input logic       reg_uv,
  input logic       ot_event,
  input logic       ot_release,
  input logic       stby_n,
  input logic       rst_pin,
  input logic       bus_wake,
  input logic [4:0] mode_oh,
  input logic       reg_en,
  input logic       xcvr_en,
  input logic       rstn_out,
  input logic       rxd_low
);
  int unsigned rcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rcnt <= 0;
    else if (mode_oh[1] && !reg_uv)
      rcnt <= (rcnt < RST_CYC) ? rcnt + 1 : rcnt;
    else
      rcnt <= 0;
  end

  AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode_oh) == 1); // R1
  AST_BATUV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    bat_uv |=> mode_oh[0]); // R2
  AST_OT_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    (!bat_uv && ot_event && !mode_oh[0]) |=> mode_oh[4]); // R3
  AST_OFF_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    mode_oh[0] |=> (mode_oh[0] || mode_oh[1])); // R4
  AST_OT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    mode_oh[4] |=> (mode_oh[4] || mode_oh[1] || mode_oh[0])); // R5
  AST_RSTN_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_oh[1] && rstn_out) |-> (rcnt >= RST_CYC)); // R6
  AST_RESET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_oh[1] && !rstn_out) |=> !mode_oh[2]); // R6
  AST_RSTN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_oh[0] || mode_oh[4]) |-> !rstn_out); // R7
  AST_RST_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_oh[2] || mode_oh[3]) && !bat_uv && !ot_event && (reg_uv || !rst_pin))
    |=> mode_oh[1]); // R7
  AST_STBY_EN: assert property (@(posedge clk) disable iff (!rst_n)
    mode_oh[2] |-> (reg_en && !xcvr_en)); // R8
  AST_WAKE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_oh[2] && bus_wake && !bat_uv && !ot_event && !reg_uv && rst_pin && !stby_n)
    |=> rxd_low); // R9
  AST_WAKE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_oh[2] |-> !rxd_low); // R9

  wire unused_ok = bat_pon ^ ot_release;
endmodule

bind pwr_mode_sup pms_checker #(.RST_CYC(RST_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .bat_pon(bat_pon), .bat_uv(bat_uv), .reg_uv(reg_uv),
  .ot_event(ot_event), .ot_release(ot_release), .stby_n(stby_n), .rst_pin(rst_pin),
  .bus_wake(bus_wake), .mode_oh(mode_oh), .reg_en(reg_en), .xcvr_en(xcvr_en),
  .rstn_out(rstn_out), .rxd_low(rxd_low)
);

// File: tb/pwr_mode_sup_tb_top.sv
`timescale 1ns/1ps
module pwr_mode_sup_tb_top;
  localparam int RC = 3;
  localparam int OFF = 0, RST = 1, SBY = 2, NRM = 3, OVT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bat_pon = 0, bat_uv = 0, reg_uv = 0, ot_event = 0, ot_release = 0;
  logic stby_n = 0, bus_wake = 0, ext_hold = 0;
  logic rst_pin;
  logic [4:0] mode_oh;
  logic reg_en, xcvr_en, rstn_out, rxd_low;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign rst_pin = rstn_out & ~ext_hold;

  pwr_mode_sup #(.RST_CYC(RC)) dut_i (
    .clk(clk), .rst_n(rst_n), .bat_pon(bat_pon), .bat_uv(bat_uv), .reg_uv(reg_uv),
    .ot_event(ot_event), .ot_release(ot_release), .stby_n(stby_n), .rst_pin(rst_pin),
    .bus_wake(bus_wake), .mode_oh(mode_oh), .reg_en(reg_en), .xcvr_en(xcvr_en),
    .rstn_out(rstn_out), .rxd_low(rxd_low)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_in();
    bat_pon = 0; bat_uv = 0; reg_uv = 0; ot_event = 0; ot_release = 0;
    stby_n = 0; bus_wake = 0; ext_hold = 0;
  endtask

  task automatic goto(int m);
    clear_in();
    rst_n = 0;
    step();
    rst_n = 1;
    step();
    if (m == OFF) return;
    bat_pon = 1; step(); bat_pon = 0;
    if (m == RST) return;
    repeat (RC + 1) step();
    if (m == NRM) begin stby_n = 1; step(); end
    if (m == OVT) begin ot_event = 1; step(); ot_event = 0; end
  endtask

  function automatic int exp_next(int m, bit buv, bit ot, bit ruv, bit go, bit sn);
    if (buv) return OFF;
    if (m == OFF) return go ? RST : OFF;
    if (ot) return OVT;
    if (m == OVT) return go ? RST : OVT;
    if (ruv) return RST;
    if (m == RST) return RST;
    return sn ? NRM : SBY;
  endfunction

  function automatic string exp_tag(int m, bit buv, bit ot, bit ruv);
    if (buv) return "R2";
    if (m == OFF) return "R4";
    if (ot) return "R3";
    if (m == OVT) return "R5";
    if (ruv) return "R7";
    if (m == RST) return "R6";
    return "R8";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step();
    chk("R1", "reset mode", int'(mode_oh), 1);
    chk("R1", "reset outputs", int'({reg_en, xcvr_en, rstn_out, rxd_low}), 0);
    rst_n = 1;

    // R6 release timing
    goto(RST);
    for (int k = 0; k < RC; k++) begin
      chk("R6", "rstn early", int'(rstn_out), 0);
      step();
    end
    chk("R6", "rstn released", int'(rstn_out), 1);
    chk("R6", "still reset", int'(mode_oh), 1 << RST);
    step();
    chk("R6", "exit to standby", int'(mode_oh), 1 << SBY);

    // R6 held line
    goto(RST);
    ext_hold = 1;
    repeat (RC + 3) step();
    chk("R6", "held in reset", int'(mode_oh), 1 << RST);
    chk("R6", "rstn driven high", int'(rstn_out), 1);
    ext_hold = 0;
    step();
    chk("R6", "exit after hold", int'(mode_oh), 1 << SBY);

    // R6 restart by reg_uv
    goto(RST);
    step(); step();
    reg_uv = 1; step(); reg_uv = 0;
    chk("R6", "restart mode", int'(mode_oh), 1 << RST);
    for (int k = 0; k < RC; k++) begin
      chk("R6", "rstn after restart", int'(rstn_out), 0);
      step();
    end
    chk("R6", "rstn after restart done", int'(rstn_out), 1);

    // R7 external pull in Normal
    goto(NRM);
    chk("R8", "normal xcvr", int'(xcvr_en), 1);
    ext_hold = 1; step();
    chk("R7", "pin pull to reset", int'(mode_oh), 1 << RST);
    chk("R7", "rstn low", int'(rstn_out), 0);
    ext_hold = 0;

    // R9 wake flag
    goto(SBY);
    chk("R9", "no wake", int'(rxd_low), 0);
    bus_wake = 1; step(); bus_wake = 0;
    chk("R9", "wake set", int'(rxd_low), 1);
    step(); step();
    chk("R9", "wake held", int'(rxd_low), 1);
    stby_n = 1; step();
    chk("R9", "cleared leaving", int'(rxd_low), 0);
    bus_wake = 1; step(); bus_wake = 0;
    chk("R9", "ignored in normal", int'(rxd_low), 0);
    stby_n = 0; step();
    chk("R9", "back in standby no flag", int'(rxd_low), 0);
    chk("R8", "standby again", int'(mode_oh), 1 << SBY);

    // R2..R8 sweep
    for (int m = 0; m < 5; m++) begin
      for (int v = 0; v < 32; v++) begin
        int e;
        string t;
        goto(m);
        bat_uv = v[0]; ot_event = v[1]; reg_uv = v[2];
        bat_pon = v[3]; ot_release = v[3]; stby_n = v[4];
        e = exp_next(m, v[0], v[1], v[2], v[3], v[4]);
        t = exp_tag(m, v[0], v[1], v[2]);
        step();
        chk(t, $sformatf("sweep m=%0d v=%0d mode", m, v), int'(mode_oh), 1 << e);
        chk("R8", $sformatf("sweep m=%0d v=%0d en", m, v), int'({reg_en, xcvr_en}),
            ((e == RST || e == SBY || e == NRM) ? 2 : 0) + ((e == NRM) ? 1 : 0));
        if (e == OFF || e == OVT || e == SBY || e == NRM)
          chk("R7", $sformatf("sweep m=%0d v=%0d rstn", m, v), int'(rstn_out),
              (e == SBY || e == NRM) ? 1 : 0);
        clear_in();
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule